// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Commit Controller

This block sits at the retirement end of an out-of-order core. Each cycle an external thread selector and reorder buffer present up to `WIDTH` candidate head entries, already ordered into slots 0 to `WIDTH-1`. For each slot the block sees a few status bits and a sequence number. Walking the slots in order, it decides whether each entry retires, whether commit stalls, or whether a request goes back to the execute stage.

Ordinary executed entries retire and count toward the commit bandwidth. Squashed entries leave without using up a commit. Non-speculative and barrier operations, and faults, are serialised: they may act only when nothing has committed earlier in the cycle and no stores are waiting to drain. An unexecuted load at the head is sent back to execute as an uncached access.

A fault raises a trap-pending state. That state blocks commit until a squash pulse fires a fixed latency later. Saturating counters record instructions done, squashed retirements, cycles at full bandwidth, and a histogram of commits per cycle.

Top module: `commit_ctrl`

## Requirements
- R1: Slots are examined from slot 0 upward. Examination stops at the first slot that is not valid or not ready. `retire_o` bit i (slot i) is registered and visible one cycle after the inputs, so its set bits always form a contiguous run starting at bit 0.
- R2: A valid, ready head with the squashed bit set retires and processing continues. It is not counted as committed, and the squashed-retire counter rises by one.
- R3: A valid, ready, executed, non-faulting head commits: it retires, and processing continues. `done_seq_o` takes the sequence number of the last entry committed in that cycle and otherwise holds its value.
- R4: An unexecuted head with the non-speculative bit set always ends the cycle's commit. It produces a request (`exreq_vld_o`=1, `exreq_unc_o`=0, `exreq_seq_o` = its sequence number) only if no entry has committed earlier in that cycle and `stores_pend_i` is low. When no request is made, `exreq_seq_o` and `exreq_unc_o` are 0.
- R5: An unexecuted head that is a load, and not non-speculative, produces a request with `exreq_unc_o`=1 and its sequence number, in any slot, and ends the cycle. An unexecuted head that is neither stalls with no request.
- R6: An executed head with the fault bit set never retires and ends the cycle. It enters trap-pending only if no entry has committed earlier in the cycle and `stores_pend_i` is low.
- R7: `trap_squash_o` pulses for one cycle exactly `TRAP_LAT` cycles after `trap_pend_o` rises, and `trap_pend_o` falls in the same cycle. While trap-pending is held, nothing retires and no request is issued.
- R8: A committed head with the no-count bit set (nop or instruction prefetch) retires normally but does not increment `done_cnt_o`.
- R9: `full_cnt_o` increments in each cycle where the committed count (excluding squashed retirements) equals `WIDTH`.
- R10: Histogram bin n (`hist_o` bits `[n*CNTW +: CNTW]`, n = 0..WIDTH) increments in every non-reset cycle that commits exactly n entries. This bin and every other counter saturate at all ones and never wrap.
- R11: Reset (synchronous, active high) clears all outputs and counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld_i | input | WIDTH | Slot holds a selectable head |
| slot_rdy_i | input | WIDTH | Head may be committed |
| slot_sqsh_i | input | WIDTH | Head was squashed |
| slot_exec_i | input | WIDTH | Head has executed |
| slot_nspec_i | input | WIDTH | Head is non-speculative, barrier or store-conditional |
| slot_load_i | input | WIDTH | Head is a load |
| slot_fault_i | input | WIDTH | Head carries a fault |
| slot_nocnt_i | input | WIDTH | Head is a nop or instruction prefetch |
| slot_seq_i | input | WIDTH*SEQW | Sequence numbers, slot i at [i*SEQW +: SEQW] |
| stores_pend_i | input | 1 | Stores still waiting to write back |
| retire_o | output | WIDTH | Per-slot retire strobe |
| done_seq_o | output | SEQW | Youngest committed sequence number |
| exreq_vld_o | output | 1 | Execute request valid |
| exreq_unc_o | output | 1 | Request is an uncached load |
| exreq_seq_o | output | SEQW | Request sequence number |
| trap_pend_o | output | 1 | Trap pending |
| trap_squash_o | output | 1 | Trap squash pulse |
| done_cnt_o | output | CNTW | Instructions done |
| sq_cnt_o | output | CNTW | Squashed retirements |
| full_cnt_o | output | CNTW | Full-bandwidth cycles |
| hist_o | output | (WIDTH+1)*CNTW | Commits-per-cycle histogram |

## Verification
Directed patterns place each kind of head in slot 0 and in later slots, with the store-drain flag both high and low. This separates the first-slot rule from the store rule for serialising and faulting entries, and it separates uncached loads, which ignore both rules. Squashed heads placed ahead of ordinary ones show that bandwidth counting excludes them. A fault followed by ready traffic measures the exact squash latency and the blocking window. Long random mixes then compare every output and counter against a reference walk of the slots each cycle, with counter widths reduced so that saturation is reached.

// File: rtl/commit_pkg.sv
package commit_pkg;
  typedef struct packed {
    logic vld;
    logic rdy;
    logic sqsh;
    logic exec;
    logic nspec;
    logic load;
    logic fault;
    logic nocnt;
  } slot_flags_t;
endpackage

// File: rtl/commit_sat_ctr.sv
module commit_sat_ctr #(
  parameter int CNTW = 32,
  parameter int IW   = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   inc,
  output logic [CNTW-1:0] cnt
);
  logic [CNTW:0] sum;
  assign sum = {1'b0, cnt} + (CNTW+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= sum[CNTW] ? '1 : sum[CNTW-1:0];
  end

  AST_CTR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt >= $past(cnt)); // R10
endmodule

// File: rtl/commit_slot_chain.sv
module commit_slot_chain
  import commit_pkg::*;
#(
  parameter int W    = 4,
  parameter int SEQW = 16,
  localparam int CW  = $clog2(W+1)
) (
  input  slot_flags_t      fl  [W],
  input  logic [SEQW-1:0]  seq [W],
  input  logic             stores_pend,
  input  logic             hold,
  output logic [W-1:0]     ret,
  output logic [CW-1:0]    ncom,
  output logic [CW-1:0]    nsq,
  output logic [CW-1:0]    ndone,
  output logic             req_vld,
  output logic             req_unc,
  output logic [SEQW-1:0]  req_seq,
  output logic             trap_go,
  output logic             done_vld,
  output logic [SEQW-1:0]  done_seq
);
  logic go;

  always_comb begin
    go       = !hold;
    ret      = '0;
    ncom     = '0;
    nsq      = '0;
    ndone    = '0;
    req_vld  = 1'b0;
    req_unc  = 1'b0;
    req_seq  = '0;
    trap_go  = 1'b0;
    done_vld = 1'b0;
    done_seq = '0;
    for (int i = 0; i < W; i++) begin
      if (go) begin
        if (!fl[i].vld || !fl[i].rdy) begin
          go = 1'b0;
        end else if (fl[i].sqsh) begin
          ret[i] = 1'b1;
          nsq    = nsq + CW'(1);
        end else if (!fl[i].exec) begin
          if (fl[i].nspec) begin
            if (ncom == '0 && !stores_pend) begin
              req_vld = 1'b1;
              req_seq = seq[i];
            end
          end else if (fl[i].load) begin
            req_vld = 1'b1;
            req_unc = 1'b1;
            req_seq = seq[i];
          end
          go = 1'b0;
        end else if (fl[i].fault) begin
          if (ncom == '0 && !stores_pend) trap_go = 1'b1;
          go = 1'b0;
        end else begin
          ret[i]   = 1'b1;
          ncom     = ncom + CW'(1);
          done_vld = 1'b1;
          done_seq = seq[i];
          if (!fl[i].nocnt) ndone = ndone + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/commit_trap_timer.sv
module commit_trap_timer #(
  parameter int LAT = 3,
  localparam int LW = $clog2(LAT+1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trap_go,
  output logic pend,
  output logic squash
);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      squash <= 1'b0;
      cnt    <= '0;
    end else begin
      squash <= 1'b0;
      if (trap_go && !pend) begin
        pend <= 1'b1;
        cnt  <= LW'(LAT);
      end else if (pend) begin
        if (cnt == LW'(1)) begin
          pend   <= 1'b0;
          squash <= 1'b1;
        end else begin
          cnt <= cnt - LW'(1);
        end
      end
    end
  end

  AST_SQUASH_AFTER_PEND: assert property (@(posedge clk) disable iff (rst)
    squash |-> ($past(pend) && !pend)); // R7
  AST_SQUASH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    squash |=> !squash); // R7
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import commit_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int SEQW     = 16,
  parameter int CNTW     = 32,
  parameter int TRAP_LAT = 3,
  localparam int CW      = $clog2(WIDTH+1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WIDTH-1:0]          slot_vld_i,
  input  logic [WIDTH-1:0]          slot_rdy_i,
  input  logic [WIDTH-1:0]          slot_sqsh_i,
  input  logic [WIDTH-1:0]          slot_exec_i,
  input  logic [WIDTH-1:0]          slot_nspec_i,
  input  logic [WIDTH-1:0]          slot_load_i,
  input  logic [WIDTH-1:0]          slot_fault_i,
  input  logic [WIDTH-1:0]          slot_nocnt_i,
  input  logic [WIDTH*SEQW-1:0]     slot_seq_i,
  input  logic                      stores_pend_i,
  output logic [WIDTH-1:0]          retire_o,
  output logic [SEQW-1:0]           done_seq_o,
  output logic                      exreq_vld_o,
  output logic                      exreq_unc_o,
  output logic [SEQW-1:0]           exreq_seq_o,
  output logic                      trap_pend_o,
  output logic                      trap_squash_o,
  output logic [CNTW-1:0]           done_cnt_o,
  output logic [CNTW-1:0]           sq_cnt_o,
  output logic [CNTW-1:0]           full_cnt_o,
  output logic [(WIDTH+1)*CNTW-1:0] hist_o
);
  slot_flags_t     fl  [WIDTH];
  logic [SEQW-1:0] seq [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slot
    assign fl[i] = '{vld: slot_vld_i[i], rdy: slot_rdy_i[i], sqsh: slot_sqsh_i[i],
                     exec: slot_exec_i[i], nspec: slot_nspec_i[i], load: slot_load_i[i],
                     fault: slot_fault_i[i], nocnt: slot_nocnt_i[i]};
    assign seq[i] = slot_seq_i[i*SEQW +: SEQW];
  end

  logic [WIDTH-1:0] ret;
  logic [CW-1:0]    ncom, nsq, ndone;
  logic             req_vld, req_unc, trap_go, done_vld;
  logic [SEQW-1:0]  req_seq, done_seq;

  commit_slot_chain #(.W(WIDTH), .SEQW(SEQW)) u_chain (
    .fl(fl), .seq(seq), .stores_pend(stores_pend_i), .hold(trap_pend_o),
    .ret(ret), .ncom(ncom), .nsq(nsq), .ndone(ndone),
    .req_vld(req_vld), .req_unc(req_unc), .req_seq(req_seq),
    .trap_go(trap_go), .done_vld(done_vld), .done_seq(done_seq)
  );

  commit_trap_timer #(.LAT(TRAP_LAT)) u_trap (
    .clk(clk), .rst(rst), .trap_go(trap_go),
    .pend(trap_pend_o), .squash(trap_squash_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      retire_o    <= '0;
      exreq_vld_o <= 1'b0;
      exreq_unc_o <= 1'b0;
      exreq_seq_o <= '0;
      done_seq_o  <= '0;
    end else begin
      retire_o    <= ret;
      exreq_vld_o <= req_vld;
      exreq_unc_o <= req_unc;
      exreq_seq_o <= req_seq;
      if (done_vld) done_seq_o <= done_seq;
    end
  end

  commit_sat_ctr #(.CNTW(CNTW), .IW(CW)) u_done_ctr (
    .clk(clk), .rst(rst), .inc(ndone), .cnt(done_cnt_o));
  commit_sat_ctr #(.CNTW(CNTW), .IW(CW)) u_sq_ctr (
    .clk(clk), .rst(rst), .inc(nsq), .cnt(sq_cnt_o));
  commit_sat_ctr #(.CNTW(CNTW), .IW(1)) u_full_ctr (
    .clk(clk), .rst(rst), .inc(ncom == CW'(WIDTH)), .cnt(full_cnt_o));

  for (genvar n = 0; n <= WIDTH; n++) begin : g_hist
    commit_sat_ctr #(.CNTW(CNTW), .IW(1)) u_bin (
      .clk(clk), .rst(rst), .inc(ncom == CW'(n)), .cnt(hist_o[n*CNTW +: CNTW]));
  end

  AST_RET_CONTIG: assert property (@(posedge clk) disable iff (rst)
    ((retire_o + WIDTH'(1)) & retire_o) == '0); // R1
  AST_NSPEC_NO_STORES: assert property (@(posedge clk) disable iff (rst)
    (exreq_vld_o && !exreq_unc_o) |-> $past(!stores_pend_i)); // R4
  AST_TRAP_NO_STORES: assert property (@(posedge clk) disable iff (rst)
    $rose(trap_pend_o) |-> $past(!stores_pend_i)); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(trap_pend_o) |-> (retire_o == '0 && !exreq_vld_o)); // R7
endmodule

// File: tb/commit_ctrl_tb.sv
module commit_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int W      = 4;
  localparam int SEQW   = 16;
  localparam int CNTW   = 8;
  localparam int LAT    = 3;
  localparam int MAXC   = (1 << CNTW) - 1;

  logic clk = 0;
  logic rst = 1;
  logic [W-1:0] iv, ir, isq, ie, ins, il, ift, inc;
  logic [W*SEQW-1:0] iseq;
  logic stp;
  logic [W-1:0] retire_o;
  logic [SEQW-1:0] done_seq_o, exreq_seq_o;
  logic exreq_vld_o, exreq_unc_o, trap_pend_o, trap_squash_o;
  logic [CNTW-1:0] done_cnt_o, sq_cnt_o, full_cnt_o;
  logic [(W+1)*CNTW-1:0] hist_o;

  always #(PERIOD/2) clk = ~clk;

  commit_ctrl #(.WIDTH(W), .SEQW(SEQW), .CNTW(CNTW), .TRAP_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .slot_vld_i(iv), .slot_rdy_i(ir), .slot_sqsh_i(isq),
    .slot_exec_i(ie), .slot_nspec_i(ins), .slot_load_i(il), .slot_fault_i(ift),
    .slot_nocnt_i(inc), .slot_seq_i(iseq), .stores_pend_i(stp),
    .retire_o(retire_o), .done_seq_o(done_seq_o), .exreq_vld_o(exreq_vld_o),
    .exreq_unc_o(exreq_unc_o), .exreq_seq_o(exreq_seq_o), .trap_pend_o(trap_pend_o),
    .trap_squash_o(trap_squash_o), .done_cnt_o(done_cnt_o), .sq_cnt_o(sq_cnt_o),
    .full_cnt_o(full_cnt_o), .hist_o(hist_o));

  int tests = 0, fails = 0;

  // reference state
  logic [W-1:0] m_ret;
  logic m_rv, m_ru, m_pend, m_sqo;
  logic [SEQW-1:0] m_rs, m_dseq;
  int m_cnt, m_done, m_sqc, m_full;
  int m_hist [W+1];

  function automatic int sat(int a, int b);
    return (a + b > MAXC) ? MAXC : a + b;
  endfunction

  task automatic model_reset();
    m_ret = '0; m_rv = 0; m_ru = 0; m_rs = '0; m_dseq = '0;
    m_pend = 0; m_sqo = 0; m_cnt = 0; m_done = 0; m_sqc = 0; m_full = 0;
    for (int n = 0; n <= W; n++) m_hist[n] = 0;
  endtask

  task automatic model_step();
    logic go;
    logic tg;
    int nc, nsq, nd;
    go = !m_pend; tg = 0; nc = 0; nsq = 0; nd = 0;
    m_ret = '0; m_rv = 0; m_ru = 0; m_rs = '0;
    for (int i = 0; i < W; i++) begin
      if (go) begin
        if (!(iv[i] && ir[i])) go = 0;
        else if (isq[i]) begin m_ret[i] = 1; nsq++; end
        else if (!ie[i]) begin
          if (ins[i]) begin
            if (nc == 0 && !stp) begin m_rv = 1; m_rs = iseq[i*SEQW +: SEQW]; end
          end else if (il[i]) begin
            m_rv = 1; m_ru = 1; m_rs = iseq[i*SEQW +: SEQW];
          end
          go = 0;
        end else if (ift[i]) begin
          if (nc == 0 && !stp) tg = 1;
          go = 0;
        end else begin
          m_ret[i] = 1; nc++; m_dseq = iseq[i*SEQW +: SEQW];
          if (!inc[i]) nd++;
        end
      end
    end
    m_sqo = 0;
    if (m_pend) begin
      if (m_cnt == 1) begin m_pend = 0; m_sqo = 1; end
      else m_cnt--;
    end else if (tg) begin
      m_pend = 1; m_cnt = LAT;
    end
    m_done = sat(m_done, nd);
    m_sqc  = sat(m_sqc, nsq);
    if (nc == W) m_full = sat(m_full, 1);
    m_hist[nc] = sat(m_hist[nc], 1);
  endtask

  task automatic chk(string tag, string what, longint got, longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "retire", retire_o, m_ret);
    chk(tag, "exreq_vld", exreq_vld_o, m_rv);
    chk(tag, "exreq_unc", exreq_unc_o, m_ru);
    chk(tag, "exreq_seq", exreq_seq_o, m_rs);
    chk(tag, "done_seq", done_seq_o, m_dseq);
    chk(tag, "trap_pend", trap_pend_o, m_pend);
    chk(tag, "trap_squash", trap_squash_o, m_sqo);
    chk(tag, "done_cnt", done_cnt_o, m_done);
    chk(tag, "sq_cnt", sq_cnt_o, m_sqc);
    chk(tag, "full_cnt", full_cnt_o, m_full);
    for (int n = 0; n <= W; n++) chk(tag, "hist", hist_o[n*CNTW +: CNTW], m_hist[n]);
  endtask

  task automatic clear_in();
    iv = '0; ir = '0; isq = '0; ie = '0; ins = '0; il = '0; ift = '0; inc = '0;
    iseq = '0; stp = 0;
  endtask

  // kind: 0 normal, 1 squashed, 2 nspec unexec, 3 load unexec, 4 fault, 5 nocnt, 6 not ready, 7 unexec other
  task automatic put(int i, int kind, int sq);
    iv[i] = 1; ir[i] = (kind != 6); isq[i] = (kind == 1);
    ie[i] = !(kind == 2 || kind == 3 || kind == 7);
    ins[i] = (kind == 2); il[i] = (kind == 3); ift[i] = (kind == 4); inc[i] = (kind == 5);
    iseq[i*SEQW +: SEQW] = SEQW'(sq);
  endtask

  task automatic all_normal(int base);
    clear_in();
    for (int i = 0; i < W; i++) put(i, 0, base + i);
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_in();
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R11");
    rst = 0;

    all_normal(16'h10); step("R3");                            // four commits, R9
    all_normal(16'h20); put(2, 6, 16'h22); step("R1");          // stop at not-ready
    all_normal(16'h30); iv[1] = 0; step("R1");                  // stop at invalid slot
    all_normal(16'h40); put(0, 1, 16'h40); step("R2");          // squashed ahead
    all_normal(16'h50); put(1, 5, 16'h51); step("R8");          // nop not counted
    clear_in(); put(0, 2, 16'h60); step("R4");                  // nspec first, drained
    clear_in(); put(0, 2, 16'h61); stp = 1; step("R4");         // stores pending
    clear_in(); put(0, 0, 16'h62); put(1, 2, 16'h63); step("R4"); // not first
    clear_in(); put(0, 1, 16'h64); put(1, 2, 16'h65); step("R4"); // squash ahead allowed
    all_normal(16'h70); put(2, 3, 16'h72); stp = 1; step("R5"); // uncached load
    clear_in(); put(0, 7, 16'h73); step("R5");                  // other unexec stalls
    all_normal(16'h80); put(1, 4, 16'h81); step("R6");          // fault not first
    clear_in(); put(0, 4, 16'h82); stp = 1; step("R6");         // fault, stores
    clear_in(); put(0, 4, 16'h83); step("R6");                  // trap enters
    for (int k = 0; k < LAT; k++) begin
      all_normal(16'h90 + 4*k); put(0, 3, 16'h90); step("R7");  // blocked until squash
    end
    all_normal(16'hA0); step("R7");                             // resumes
    for (int k = 0; k < 300; k++) begin clear_in(); step("R10"); end // bin 0 saturates
    for (int k = 0; k < 260; k++) begin all_normal(k); step("R9"); end

    for (int k = 0; k < 1500; k++) begin
      clear_in();
      for (int i = 0; i < W; i++) begin
        iv[i]  = ($urandom % 10) != 0;
        ir[i]  = ($urandom % 5) != 0;
        isq[i] = ($urandom % 7) == 0;
        ie[i]  = ($urandom % 5) != 0;
        ins[i] = ($urandom % 8) == 0;
        il[i]  = ($urandom % 8) == 0;
        ift[i] = ($urandom % 16) == 0;
        inc[i] = ($urandom % 6) == 0;
        iseq[i*SEQW +: SEQW] = SEQW'($urandom);
      end
      stp = ($urandom % 3) == 0;
      step("RND");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
  end
endmodule